// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer with Digital Zero Correction

This block is the digital half of a dual-slope integrating analog-to-digital converter. It steers the analog switches around an external integrator. These switches discharge the integrator, connect a shorted input or the real input for a fixed integration time, and then apply a reference of the right polarity. It also counts the clock cycles that the reference takes to bring the integrator back across the comparator threshold. The sign of the reading comes from the comparator state at the end of integration.

Every conversion is made of two passes. The first pass integrates a shorted input and records the offset reading of the analog path. The second pass measures the real input. The stored offset reading is subtracted from the second one, so that offset drift is removed digitally. The corrected signed value, an overrange flag and the mode that produced it are loaded together into an output register, and a one-cycle valid strobe marks the load. The sequencer runs continuously from reset.

Two resolutions are chosen at run time through one input. The high-resolution mode uses a long integration and a large count limit, and its parameters can be set for a range of ±200,000 counts. The fast mode uses one tenth of the integration time and one tenth of the count limit. The default parameters are scaled down (500/1000 and 50/100 cycles) to keep conversions short.

Top module: `dsc_convctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, sw_dump is 1 and the other four switch outputs are 0. result, result_valid, overrange and res_fast are all 0.
- R2: At most one switch output is 1 in any cycle. Each conversion runs discharge, zero-input integrate (sw_zero), hold, deintegrate, discharge, signal integrate (sw_sig), hold and deintegrate, in that order. Each integration is entered directly from discharge.
- R3: Each integration lasts exactly N cycles: N = HI_INT (500) when the latched mode is high resolution and LO_INT (50) in fast mode. Discharge lasts DUMP_CYC (4) cycles, hold lasts 1 cycle, and a deintegration that ends after k counts lasts k+1 cycles. The time between valid strobes is therefore 2*DUMP_CYC + 2*N + 2 + (kz+1) + (ks+1).
- R4: If cmp_in is 1 during the hold cycle, the deintegration drives sw_ref_dn and the pass reading is positive. If cmp_in is 0, it drives sw_ref_up and the reading is negative. The polarity never changes within a deintegration.
- R5: The magnitude of a pass reading is the number of deintegration cycles that elapse before cmp_in leaves its hold-cycle value.
- R6: result equals the signed signal-pass reading minus the signed zero-pass reading of the same conversion. A zero input therefore reads 0, whatever the sign of the offset.
- R7: The count limit is HI_MAX (1000) in high-resolution mode and LO_MAX (100) in fast mode. A reading equal to the limit is valid. If the comparator has not crossed when the count equals the limit, overrange is 1 for that result.
- R8: fast_mode (1 selects fast mode) is sampled once per conversion, on the last cycle of its first discharge. A change after that point affects only the next conversion. res_fast reports the mode that produced the current result.
- R9: result_valid is a single-cycle pulse. result, overrange and res_fast change only in the cycle in which result_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 selects fast mode, 0 selects high resolution |
| cmp_in | input | 1 | Comparator, 1 when integrator output is above threshold |
| sw_dump | output | 1 | Discharge the integrator |
| sw_zero | output | 1 | Integrate the shorted input |
| sw_sig | output | 1 | Integrate the measured input |
| sw_ref_dn | output | 1 | Apply reference that drives integrator downward |
| sw_ref_up | output | 1 | Apply reference that drives integrator upward |
| result | output | RES_W (12) | Signed offset-corrected reading |
| result_valid | output | 1 | One-cycle strobe on result update |
| overrange | output | 1 | Reading exceeded the count limit |
| res_fast | output | 1 | Mode of the current result |

## Verification
The bench drives an ideal integrator model whose reference step equals the observed integration length. It carries a non-integer offset, so both pass readings are non-zero and the zero correction has to cancel them. Readings exactly at the count limit and one count beyond it are applied in both modes. A design off by one in the limit compare would flag a legal full-scale value or miss a real overrange. Inputs of both signs with positive and negative offsets expose a swapped reference polarity or a dropped subtraction: each would show as a wrong sign or a reading shifted by the offset. A mode change made during integration must not alter that conversion's limit, integration length or res_fast. Strobe spacing and integration lengths are measured at the switch pins, so a stray cycle in any phase shows up as a timing mismatch.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_DUMP  = 2'd0,
    PH_INT   = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DEINT = 2'd3
  } phase_e;

  // Signed pass reading from a deintegration count and its polarity.
  function automatic int signed_count(input int unsigned cnt, input logic neg);
    int mag;
    mag = int'(cnt);
    return neg ? -mag : mag;
  endfunction

  // Digital zero correction: signal pass minus zero pass.
  function automatic int zero_corrected(input int sig_raw, input int zero_raw);
    return sig_raw - zero_raw;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int HI_INT   = 500,
  parameter int HI_MAX   = 1000,
  parameter int LO_INT   = 50,
  parameter int LO_MAX   = 100,
  parameter int DUMP_CYC = 4,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_mode,
  input  logic             cmp_in,
  output logic             sw_dump,
  output logic             sw_zero,
  output logic             sw_sig,
  output logic             sw_ref_dn,
  output logic             sw_ref_up,
  output logic             pass_done,
  output logic             pass_is_sig,
  output logic [CNT_W-1:0] pass_count,
  output logic             pass_neg,
  output logic             pass_ovr,
  output logic             conv_fast
);

  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] DUMP_LAST = CNT_W'(DUMP_CYC - 1);

  phase_e           ph;
  logic             pass;      // 0: zero-input pass, 1: signal pass
  logic [CNT_W-1:0] cnt;
  logic             sign_neg;

  // Limits of the conversion in flight, from the latched mode.
  logic [CNT_W-1:0] n_int;
  logic [CNT_W-1:0] m_max;
  assign n_int = conv_fast ? CNT_W'(LO_INT) : CNT_W'(HI_INT);
  assign m_max = conv_fast ? CNT_W'(LO_MAX) : CNT_W'(HI_MAX);

  // Named internal events.
  logic dump_last, int_last, crossed, hit_max, deint_end;
  assign dump_last = (ph == PH_DUMP) && (cnt == DUMP_LAST);
  assign int_last  = (ph == PH_INT) && (cnt == n_int - ONE);
  assign crossed   = (ph == PH_DEINT) && (cmp_in == sign_neg);
  assign hit_max   = (ph == PH_DEINT) && !crossed && (cnt == m_max);
  assign deint_end = crossed || hit_max;

  // Switch outputs decoded from registered state.
  assign sw_dump   = (ph == PH_DUMP);
  assign sw_zero   = (ph == PH_INT) && !pass;
  assign sw_sig    = (ph == PH_INT) && pass;
  assign sw_ref_dn = (ph == PH_DEINT) && !sign_neg;
  assign sw_ref_up = (ph == PH_DEINT) && sign_neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_DUMP;
      pass        <= 1'b0;
      cnt         <= '0;
      sign_neg    <= 1'b0;
      conv_fast   <= 1'b0;
      pass_done   <= 1'b0;
      pass_is_sig <= 1'b0;
      pass_count  <= '0;
      pass_neg    <= 1'b0;
      pass_ovr    <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      unique case (ph)
        PH_DUMP: begin
          if (dump_last) begin
            ph  <= PH_INT;
            cnt <= '0;
            if (!pass) conv_fast <= fast_mode;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_INT: begin
          if (int_last) begin
            ph  <= PH_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_HOLD: begin
          sign_neg <= !cmp_in;
          ph       <= PH_DEINT;
          cnt      <= '0;
        end
        PH_DEINT: begin
          if (deint_end) begin
            pass_done   <= 1'b1;
            pass_is_sig <= pass;
            pass_count  <= cnt;
            pass_neg    <= sign_neg;
            pass_ovr    <= hit_max;
            pass        <= !pass;
            ph          <= PH_DUMP;
            cnt         <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: ph <= PH_DUMP;
      endcase
    end
  end

  // R2: never two switches closed at once.
  p_sw_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_dump, sw_zero, sw_sig, sw_ref_dn, sw_ref_up}));

  // R2: each integration starts straight out of discharge.
  p_zero_after_dump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_zero) |-> $past(sw_dump));
  p_sig_after_dump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_sig) |-> $past(sw_dump));

  // R4: reference polarity never reverses inside a deintegration.
  p_ref_dn_no_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ref_dn |=> !sw_ref_up);
  p_ref_up_no_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ref_up |=> !sw_ref_dn);

  // R7: the deintegration count never runs past the limit.
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DEINT) |-> (cnt <= m_max));

  // R8: latched mode changes only at the end of a conversion's first discharge.
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conv_fast) |-> $past((ph == PH_DUMP) && !pass));

endmodule

// File: rtl/dsc_result.sv
module dsc_result
  import dsc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RES_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pass_done,
  input  logic                    pass_is_sig,
  input  logic [CNT_W-1:0]        pass_count,
  input  logic                    pass_neg,
  input  logic                    pass_ovr,
  input  logic                    conv_fast,
  output logic signed [RES_W-1:0] result,
  output logic                    result_valid,
  output logic                    overrange,
  output logic                    res_fast
);

  logic signed [RES_W-1:0] raw;
  logic signed [RES_W-1:0] zero_raw;
  logic                    zero_ovr;
  logic                    load_zero, load_sig;

  assign raw       = RES_W'(signed_count(32'(pass_count), pass_neg));
  assign load_zero = pass_done && !pass_is_sig;
  assign load_sig  = pass_done && pass_is_sig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_raw     <= '0;
      zero_ovr     <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
      overrange    <= 1'b0;
      res_fast     <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (load_zero) begin
        zero_raw <= raw;
        zero_ovr <= pass_ovr;
      end
      if (load_sig) begin
        result       <= RES_W'(zero_corrected(int'(raw), int'(zero_raw)));
        overrange    <= pass_ovr || zero_ovr;
        res_fast     <= conv_fast;
        result_valid <= 1'b1;
      end
    end
  end

  // R9: strobe is one cycle wide.
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R9: output register moves only with the strobe.
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(overrange) && $stable(res_fast)));

endmodule

// File: rtl/dsc_convctl.sv
module dsc_convctl
  import dsc_pkg::*;
#(
  parameter int HI_INT   = 500,
  parameter int HI_MAX   = 1000,
  parameter int LO_INT   = 50,
  parameter int LO_MAX   = 100,
  parameter int DUMP_CYC = 4,
  parameter int CNT_W    = $clog2(max2(max2(HI_MAX, HI_INT), DUMP_CYC) + 1),
  parameter int RES_W    = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fast_mode,
  input  logic                    cmp_in,
  output logic                    sw_dump,
  output logic                    sw_zero,
  output logic                    sw_sig,
  output logic                    sw_ref_dn,
  output logic                    sw_ref_up,
  output logic signed [RES_W-1:0] result,
  output logic                    result_valid,
  output logic                    overrange,
  output logic                    res_fast
);

  logic             pass_done;
  logic             pass_is_sig;
  logic [CNT_W-1:0] pass_count;
  logic             pass_neg;
  logic             pass_ovr;
  logic             conv_fast;

  dsc_sequencer #(
    .HI_INT  (HI_INT),
    .HI_MAX  (HI_MAX),
    .LO_INT  (LO_INT),
    .LO_MAX  (LO_MAX),
    .DUMP_CYC(DUMP_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_mode  (fast_mode),
    .cmp_in     (cmp_in),
    .sw_dump    (sw_dump),
    .sw_zero    (sw_zero),
    .sw_sig     (sw_sig),
    .sw_ref_dn  (sw_ref_dn),
    .sw_ref_up  (sw_ref_up),
    .pass_done  (pass_done),
    .pass_is_sig(pass_is_sig),
    .pass_count (pass_count),
    .pass_neg   (pass_neg),
    .pass_ovr   (pass_ovr),
    .conv_fast  (conv_fast)
  );

  dsc_result #(
    .CNT_W(CNT_W),
    .RES_W(RES_W)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .pass_done   (pass_done),
    .pass_is_sig (pass_is_sig),
    .pass_count  (pass_count),
    .pass_neg    (pass_neg),
    .pass_ovr    (pass_ovr),
    .conv_fast   (conv_fast),
    .result      (result),
    .result_valid(result_valid),
    .overrange   (overrange),
    .res_fast    (res_fast)
  );

  // R1: discharge is the only closed switch straight after reset.
  p_reset_dump_r1: assert property (@(posedge clk)
    !rst_n |=> (sw_dump && !sw_zero && !sw_sig && !sw_ref_dn && !sw_ref_up));

endmodule

// File: tb/dsc_convctl_bench.sv
`timescale 1ns/1ps
module dsc_convctl_bench;

  localparam int HI_INT = 500, HI_MAX = 1000, LO_INT = 50, LO_MAX = 100, DUMP_CYC = 4;
  localparam int RES_W = 12;
  localparam int NV = 12;
  localparam int VEC_X [NV] = '{0, 1, -1, 500, -500, 999, -999, 1000, 0, 99, 100, -100};
  localparam bit VEC_F [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0;
  logic cmp_in;
  logic sw_dump, sw_zero, sw_sig, sw_ref_dn, sw_ref_up;
  logic signed [RES_W-1:0] result;
  logic result_valid, overrange, res_fast;

  always #5 clk = ~clk;

  dsc_convctl u_dsc_convctl (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .cmp_in(cmp_in),
    .sw_dump(sw_dump), .sw_zero(sw_zero), .sw_sig(sw_sig),
    .sw_ref_dn(sw_ref_dn), .sw_ref_up(sw_ref_up),
    .result(result), .result_valid(result_valid),
    .overrange(overrange), .res_fast(res_fast)
  );

  // Ideal integrator: reference step equals the observed integration length.
  real x_in = 0.0;
  real off = 0.37;
  real v = 0.0;
  int  int_len = 0;
  always @(posedge clk) begin
    if (sw_dump) begin
      v <= 0.0; int_len <= 0;
    end else if (sw_zero) begin
      v <= v + off; int_len <= int_len + 1;
    end else if (sw_sig) begin
      v <= v + x_in + off; int_len <= int_len + 1;
    end else if (sw_ref_dn) begin
      v <= v - real'(int_len);
    end else if (sw_ref_up) begin
      v <= v + real'(int_len);
    end
  end
  assign cmp_in = (v > 0.0);

  // Port monitor, one conversion at a time (between strobes).
  int zc = 0, sc = 0, zc_at_sig = -1, cyc = 0;
  bit saw_dn = 0, saw_up = 0, in_sig = 0;
  int cap_zc, cap_sc, cap_zsig, cap_period;
  bit cap_dn, cap_up;
  int multi_viol = 0, hold_viol = 0, pulse_viol = 0;
  logic signed [RES_W-1:0] prev_res = '0;
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({sw_dump, sw_zero, sw_sig, sw_ref_dn, sw_ref_up}) > 1) multi_viol++;
      if (!result_valid && result != prev_res) hold_viol++;
      if (result_valid && prev_valid) pulse_viol++;
      if (result_valid) begin
        cap_zc = zc; cap_sc = sc; cap_zsig = zc_at_sig;
        cap_dn = saw_dn; cap_up = saw_up; cap_period = cyc;
        zc = 0; sc = 0; zc_at_sig = -1; saw_dn = 0; saw_up = 0; in_sig = 0; cyc = 1;
      end else begin
        cyc++;
        if (sw_zero) zc++;
        if (sw_sig) begin
          if (!in_sig) zc_at_sig = zc;
          in_sig = 1; sc++;
        end
        if (in_sig && sw_ref_dn) saw_dn = 1;
        if (in_sig && sw_ref_up) saw_up = 1;
      end
    end
    prev_res = result;
    prev_valid = result_valid;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mag_of(input real y);
    return int'($ceil((y < 0.0) ? -y : y));
  endfunction

  function automatic int reading(input real y);
    return (y < 0.0) ? -mag_of(y) : mag_of(y);
  endfunction

  task automatic wait_valid();
    do @(negedge clk); while (!result_valid);
    #1;
  endtask

  task automatic run_conv(input real x, input bit f);
    x_in = x; fast_mode = f;
    wait_valid();
  endtask

  // Checks one completed conversion against the requirements.
  task automatic check_conv(input real x, input bit f);
    real y;
    int n, m, kz, ks, exp_res;
    bit ovr;
    y = x + off;
    n = f ? LO_INT : HI_INT;
    m = f ? LO_MAX : HI_MAX;
    kz = mag_of(off);
    ks = mag_of(y);
    ovr = (ks > m);
    exp_res = reading(y) - reading(off);
    chk("R7", "overrange", int'(overrange), int'(ovr));
    if (!ovr) chk("R5 R6", "result", int'(result), exp_res);
    chk("R8", "res_fast", int'(res_fast), int'(f));
    chk("R3", "zero integrate cycles", cap_zc, n);
    chk("R3", "signal integrate cycles", cap_sc, n);
    chk("R2", "zero pass done before signal pass", cap_zsig, n);
    chk("R4", "ref_dn used in signal pass", int'(cap_dn), int'(y > 0.0));
    chk("R4", "ref_up used in signal pass", int'(cap_up), int'(y < 0.0));
  endtask

  int total = 0;
  always @(posedge clk) begin
    total++;
    if (total > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", total);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state.
    chk("R1", "sw_dump in reset", int'(sw_dump), 1);
    chk("R1", "other switches in reset", int'({sw_zero, sw_sig, sw_ref_dn, sw_ref_up}), 0);
    chk("R1", "result in reset", int'(result), 0);
    chk("R1", "flags in reset", int'({result_valid, overrange, res_fast}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sw_dump after reset", int'(sw_dump), 1);
    chk("R1", "valid after reset", int'(result_valid), 0);

    wait_valid();  // align to a conversion boundary

    for (int i = 0; i < NV; i++) begin
      run_conv(real'(VEC_X[i]), VEC_F[i]);
      check_conv(real'(VEC_X[i]), VEC_F[i]);
    end

    // R3: strobe spacing, fast mode, x = 37 (kz = 1, ks = 38).
    run_conv(37.0, 1'b1);
    check_conv(37.0, 1'b1);
    chk("R3", "fast period", cap_period, 2*DUMP_CYC + 2*LO_INT + 2 + (1+1) + (38+1));
    // R3: strobe spacing, high resolution, x = -10 (reading -10, ks = 10).
    run_conv(-10.0, 1'b0);
    check_conv(-10.0, 1'b0);
    chk("R3", "high-res period", cap_period, 2*DUMP_CYC + 2*HI_INT + 2 + (1+1) + (10+1));

    // R6: negative offset, zero input must still read 0.
    off = -0.6;
    run_conv(0.0, 1'b0);
    check_conv(0.0, 1'b0);
    chk("R6", "zero input with negative offset", int'(result), 0);
    run_conv(250.0, 1'b0);
    check_conv(250.0, 1'b0);
    run_conv(-42.0, 1'b1);
    check_conv(-42.0, 1'b1);

    // R8: mode change inside a conversion affects only the next one.
    off = 0.37;
    x_in = 150.0; fast_mode = 1'b0;
    repeat (100) @(posedge clk);
    fast_mode = 1'b1;
    wait_valid();
    check_conv(150.0, 1'b0);
    chk("R8", "old mode kept mid-conversion", int'(res_fast), 0);
    chk("R7", "150 fits high-res range", int'(overrange), 0);
    wait_valid();
    check_conv(150.0, 1'b1);
    chk("R7", "150 overranges in fast mode", int'(overrange), 1);

    // R2 / R9 global monitors.
    chk("R2", "cycles with two switches closed", multi_viol, 0);
    chk("R9", "result changes without strobe", hold_viol, 0);
    chk("R9", "strobe wider than one cycle", pulse_viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule